// File: doc/BRIEF.md
# Short Inter-Packet Gap Rate Limiter

This block decides, cycle by cycle on the wire-side clock, whether the transmitter may start its next packet after a reduced inter-packet gap. Software sets a short-gap enable to allow short gaps at all. It can also set a limit enable, which keeps the share of short-gap packets near 100 ppm of wire clocks. The transmit path raises a per-packet request when it would like a short gap. It samples the grant, and at the start of each packet it pulses a strobe together with a flag that says which gap was actually used.

When limiting is active, every packet that goes out with a short gap starts a hold-off of `HOLDOFF_CYCLES` wire clocks, 10,000 by default. During the hold-off no short gap is granted, so a packet requested in that time falls back to the normal gap. With the limit off but short gaps enabled, every request is granted. The grant is combinational, so the transmit path sees it in the same cycle as its request.

Top module: `short_gap_governor`

## Requirements
- R1: While `shortGapEn` is 0, `grant` is 0 whatever the other inputs are, and a packet-start strobe starts no hold-off.
- R2: With `shortGapEn` and `limitEn` both 1 and no hold-off running, `grant` equals `gapReq`.
- R3: With both enables at 1, a cycle with `pktStart`=1 and `pktShortGap`=1 (1 = the short gap was used) starts a hold-off. `grant` is then 0 for exactly `HOLDOFF_CYCLES` cycles after that cycle, and follows `gapReq` again in the cycle after those.
- R4: A packet start with `pktShortGap`=0 (normal gap) starts no hold-off.
- R5: During a hold-off, `grant` stays 0 even while `gapReq` is 1.
- R6: With `shortGapEn`=1 and `limitEn`=0, `grant` equals `gapReq` in every cycle, including right after short-gap packets.
- R7: Clearing either enable for one cycle cancels a running hold-off. The clear takes priority over a short-gap strobe in the same cycle, so once the enables are set again, `grant` follows `gapReq` at once.
- R8: A short-gap strobe during a hold-off restarts the full window from that strobe. This also holds in the last blocked cycle, where the reload takes priority over the final decrement.
- R9: Reset (`rstN`=0, asynchronous) clears any hold-off, so `grant` follows `gapReq` as soon as reset is asserted and after it is released.
- R10: `grant` is combinational: it changes in the same cycle as `gapReq` and the enables, with no register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Wire-side clock |
| rstN | input | 1 | Asynchronous active-low reset |
| shortGapEn | input | 1 | Allows short gaps at all |
| limitEn | input | 1 | Turns on the hold-off rate limit |
| gapReq | input | 1 | Transmit path asks for a short gap for the next packet |
| pktStart | input | 1 | One-cycle strobe at each packet start |
| pktShortGap | input | 1 | With pktStart: 1 = the packet used a short gap |
| grant | output | 1 | A short gap is allowed now |

## Verification
Two events can land on the hold-off counter in the same cycle, and each pair is forced at a chosen instant. The first pair is a new short-gap strobe and the last decrement: the strobe is placed in the exact last blocked cycle of a window, and the bench expects a full window of `HOLDOFF_CYCLES` blocked cycles to follow, not an early release. The second pair is the limit being cleared and a short-gap strobe: both arrive together, and the bench expects the grant to follow the request immediately once the limit is enabled again.

// File: rtl/sgap_pkg.sv
`timescale 1ns/1ps
package sgap_pkg;

  // Strobes from control to the hold-off datapath; priority clear > load > dec
  typedef struct packed {
    logic clear;
    logic load;
    logic dec;
  } holdoff_cmd_t;

endpackage

// File: rtl/sgap_holdoff_dp.sv
`timescale 1ns/1ps
module sgap_holdoff_dp
  import sgap_pkg::*;
#(
  parameter int HOLDOFF_CYCLES = 10000
) (
  input  logic         clk,
  input  logic         rstN,
  input  holdoff_cmd_t cmd,
  output logic         cntZero
);

  localparam int CNT_W = (HOLDOFF_CYCLES < 2) ? 1 : $clog2(HOLDOFF_CYCLES + 1);

  generate
    if (HOLDOFF_CYCLES == 0) begin : g_noHoldoff
      // A zero-length window: the limiter never blocks.
      assign cntZero = 1'b1;
    end else begin : g_counter
      localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(HOLDOFF_CYCLES);
      logic [CNT_W-1:0] count;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          count <= '0;
        end else if (cmd.clear) begin
          count <= '0;
        end else if (cmd.load) begin
          count <= LOAD_VAL;
        end else if (cmd.dec && (count != '0)) begin
          count <= count - CNT_W'(1);
        end
      end

      assign cntZero = (count == '0);

      AST_LOAD_FULL_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
        (cmd.load && !cmd.clear) |=> (count == LOAD_VAL)); // R3
      AST_COUNT_DOWN_BY_ONE: assert property (@(posedge clk) disable iff (!rstN)
        (cmd.dec && !cmd.load && !cmd.clear) |=> ((count + CNT_W'(1)) == $past(count))); // R3
      AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rstN)
        (count <= LOAD_VAL)); // R8
      AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
        cmd.clear |=> (count == '0)); // R7
    end
  endgenerate

endmodule

// File: rtl/sgap_ctrl.sv
`timescale 1ns/1ps
module sgap_ctrl
  import sgap_pkg::*;
#(
  parameter int HOLDOFF_CYCLES = 10000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         shortGapEn,
  input  logic         limitEn,
  input  logic         gapReq,
  input  logic         pktStart,
  input  logic         pktShortGap,
  input  logic         cntZero,
  output holdoff_cmd_t cmd,
  output logic         grant
);

  localparam bit HAS_WINDOW = (HOLDOFF_CYCLES > 0);

  logic limitActive;
  logic shortStart;

  assign limitActive = shortGapEn & limitEn;
  assign shortStart  = pktStart & pktShortGap;

  always_comb begin
    cmd       = '0;
    cmd.clear = !limitActive;
    cmd.load  = limitActive & shortStart;
    cmd.dec   = limitActive & !shortStart & !cntZero;
  end

  // Short gap allowed: enabled, requested, and not inside a hold-off window
  assign grant = shortGapEn & gapReq & (!limitActive | cntZero);

  AST_NO_GRANT_SG_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !shortGapEn |-> !grant); // R1
  AST_HOLDOFF_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (limitActive && !cntZero) |-> !grant); // R5
  AST_FREE_WHEN_UNLIMITED: assert property (@(posedge clk) disable iff (!rstN)
    (shortGapEn && !limitEn && gapReq) |-> grant); // R6
  AST_SHORT_START_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (HAS_WINDOW && limitActive && shortStart) |=> !cntZero); // R3
  AST_NORMAL_GAP_NO_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (limitActive && pktStart && !pktShortGap && cntZero) |=> cntZero); // R4
  AST_DISABLE_CANCELS: assert property (@(posedge clk) disable iff (!rstN)
    !limitActive |=> cntZero); // R7

endmodule

// File: rtl/short_gap_governor.sv
`timescale 1ns/1ps
module short_gap_governor
  import sgap_pkg::*;
#(
  parameter int HOLDOFF_CYCLES = 10000
) (
  input  logic clk,
  input  logic rstN,
  input  logic shortGapEn,
  input  logic limitEn,
  input  logic gapReq,
  input  logic pktStart,
  input  logic pktShortGap,
  output logic grant
);

  holdoff_cmd_t holdCmd;
  logic         holdZero;

  sgap_ctrl #(
    .HOLDOFF_CYCLES(HOLDOFF_CYCLES)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .shortGapEn (shortGapEn),
    .limitEn    (limitEn),
    .gapReq     (gapReq),
    .pktStart   (pktStart),
    .pktShortGap(pktShortGap),
    .cntZero    (holdZero),
    .cmd        (holdCmd),
    .grant      (grant)
  );

  sgap_holdoff_dp #(
    .HOLDOFF_CYCLES(HOLDOFF_CYCLES)
  ) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .cmd    (holdCmd),
    .cntZero(holdZero)
  );

endmodule

// File: tb/test_short_gap_governor.sv
`timescale 1ns/1ps
module test_short_gap_governor;

  localparam int HOLD = 10000;

  typedef struct packed {
    logic sg;
    logic lim;
    logic req;
    logic st;
    logic sh;
    logic exp;
  } vec_t;

  // sg lim req st sh exp ; hold-off counter idle throughout
  localparam vec_t VECS [13] = '{
    6'b001000, 6'b011000, 6'b001110, 6'b101001, 6'b101111,
    6'b100000, 6'b101001, 6'b111001, 6'b110000, 6'b111101,
    6'b111001, 6'b011110, 6'b111001
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic shortGapEn = 1'b0;
  logic limitEn = 1'b0;
  logic gapReq = 1'b0;
  logic pktStart = 1'b0;
  logic pktShortGap = 1'b0;
  logic grant;

  int total = 0;
  int failed = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  short_gap_governor #(.HOLDOFF_CYCLES(HOLD)) i_short_gap_governor (
    .clk(clk), .rstN(rstN), .shortGapEn(shortGapEn), .limitEn(limitEn),
    .gapReq(gapReq), .pktStart(pktStart), .pktShortGap(pktShortGap),
    .grant(grant)
  );

  task automatic checkBit(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: grant=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkInt(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // Drive one cycle's inputs after the falling edge, settle before sampling
  task automatic drive(logic sg, logic lim, logic req, logic st, logic sh);
    @(negedge clk);
    shortGapEn = sg; limitEn = lim; gapReq = req; pktStart = st; pktShortGap = sh;
    #1;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
  endtask

  // Count blocked cycles after a strobe until grant returns
  task automatic measure(string tag);
    int blocked = 0;
    for (int c = 0; c < HOLD + 10; c++) begin
      drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
      if (grant) break;
      blocked++;
    end
    checkInt(tag, blocked, HOLD);
  endtask

  initial begin
    // R9: reset state, counter clear
    drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    checkBit("R9 reset state", grant, 1'b1);
    drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    checkBit("R10 no request in reset", grant, 1'b0);
    @(negedge clk); rstN = 1'b1;

    // Vector table
    for (int i = 0; i < 13; i++) begin
      vec_t v = VECS[i];
      string tag;
      if (!v.sg) tag = "R1 vector";
      else if (!v.lim) tag = "R6 vector";
      else if (!v.req) tag = "R10 vector";
      else if (v.st && !v.sh) tag = "R4 vector";
      else tag = "R2 vector";
      drive(v.sg, v.lim, v.req, v.st, v.sh);
      checkBit($sformatf("%s %0d", tag, i), grant, v.exp);
    end

    // R3 / R5: full window length
    drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    checkBit("R2 grant before window", grant, 1'b1);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    checkBit("R5 blocked with request", grant, 1'b0);
    idle(HOLD - 2);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    checkBit("R3 last blocked cycle", grant, 1'b0);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    checkBit("R3 window over", grant, 1'b1);
    drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    checkBit("R10 request dropped", grant, 1'b0);

    drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    measure("R3 window length");

    // R8: restart mid-window
    drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    idle(5000);
    drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    checkBit("R5 mid-window strobe cycle", grant, 1'b0);
    measure("R8 restart mid-window");

    // R8: strobe in last blocked cycle (reload vs final decrement)
    drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    idle(HOLD - 1);
    drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    checkBit("R8 last-cycle strobe still blocked", grant, 1'b0);
    measure("R8 reload in last cycle");

    // R7: limit clear cancels
    drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    idle(20);
    drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    checkBit("R7 limit off grants", grant, 1'b1);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    checkBit("R7 cancelled by limit clear", grant, 1'b1);

    // R7: short-gap enable clear cancels
    drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    idle(20);
    drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    checkBit("R1 disabled during window", grant, 1'b0);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    checkBit("R7 cancelled by enable clear", grant, 1'b1);

    // R7: clear and short strobe in the same cycle
    drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    idle(3);
    drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
    checkBit("R6 unlimited during strobe", grant, 1'b1);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    checkBit("R7 clear beats load", grant, 1'b1);

    // R9: reset mid-window
    drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    idle(10);
    checkBit("R5 window before reset", grant, 1'b0);
    @(negedge clk); rstN = 1'b0; #1;
    checkBit("R9 async reset clears", grant, 1'b1);
    @(negedge clk); rstN = 1'b1;
    drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    checkBit("R9 after reset release", grant, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      failed++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

endmodule